// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the line reservations that load-linked and store-conditional pairs depend on, and decides whether each store-conditional succeeded at the moment its write completes. It sits beside a cache controller. Each completion from the controller brings the line address, the access kind, the requester id and whether the line is currently present in the cache. The cache also reports evictions. Every completion produces one result word one cycle later: 1 for success and 0 for a failed store-conditional.

A store-conditional passes only when its requester still holds a reservation on that line. Any store-conditional wipes the reservations on its line, whatever its outcome. Ordinary writes by the holder to a present line, evictions of the line, and other store-conditionals also remove a reservation. A completed locked read-modify-write read raises a one-cycle hold request for its line toward the request queue, and the matching locked write releases it. A bypass input turns off all reservation handling, for use in fabric tests.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, no result, hold or release pulse appears until a completion arrives, and no requester holds a reservation, so a first store-conditional returns 0.
- R2: A completed load-linked (kind code 2) from requester r reserves its line for r. A later store-conditional (kind code 3) from r to the same line returns result word 1 if nothing has cleared the reservation.
- R3: A store-conditional returns 0 when its requester holds no reservation on that exact line. This covers a reservation on a different line and a reservation held only by another requester.
- R4: Every store-conditional removes the reservations of all requesters on its line, whether it passes or fails.
- R5: An ordinary write (store code 1, locked read code 4, locked write code 5) by requester r to a line flagged present removes r's reservation on that line. With the line absent, or when issued by a different requester, the write leaves reservations untouched.
- R6: A load (code 0, and the unused codes 6 and 7) always returns 1 and never changes any reservation.
- R7: A completed locked read (code 4) pulses the hold output with its line on the next cycle. A completed locked write (code 5) pulses the release output the same way. No other kind pulses either output.
- R8: While bypass is high, completions neither consult nor change reservations, and every result word is 1.
- R9: An eviction removes every requester's reservation on the evicted line.
- R10: When a load-linked and an eviction of the same line arrive in the same cycle, the removal is applied first and the new reservation is kept.
- R11: Each completion yields exactly one result pulse on the following cycle, carrying the requester id and a word whose value is 0 or 1. Idle cycles yield none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | A write or read completion is presented |
| cmp_kind | input | 3 | Access kind code (see R2, R5, R6) |
| cmp_line | input | LINE_AW | Line address of the completion |
| cmp_req | input | REQ_W | Requester id of the completion |
| cmp_line_present | input | 1 | Cache reports the line as present |
| evict_valid | input | 1 | Cache evicts a line this cycle |
| evict_line | input | LINE_AW | Line address being evicted |
| bypass_en | input | 1 | Skip all reservation handling |
| res_valid | output | 1 | Result word is valid |
| res_req | output | REQ_W | Requester the result belongs to |
| res_word | output | RES_W | 1 on success, 0 on failed store-conditional |
| qhold_valid | output | 1 | Hold the request queue for a line |
| qhold_line | output | LINE_AW | Line to hold |
| qrelease_valid | output | 1 | Release the request queue for a line |
| qrelease_line | output | LINE_AW | Line to release |

## Verification
The bench builds the monitor with two requesters, four-bit line addresses and an eight-bit result word. With these sizes, every combination of acting requester, other requester, same or different line, present or absent line, and each clearing event can be swept between a load-linked and the store-conditionals that follow it. Expected results come from a small reservation table kept in the bench and updated from the requirement rules. The same-cycle load-linked and eviction case and the bypass sequences are run as directed steps.

// File: rtl/llsc_monitor_pkg.sv
package llsc_monitor_pkg;

    typedef enum logic [2:0] {
        KIND_LOAD   = 3'd0,
        KIND_STORE  = 3'd1,
        KIND_LL     = 3'd2,
        KIND_SC     = 3'd3,
        KIND_RMW_RD = 3'd4,
        KIND_RMW_WR = 3'd5
    } op_kind_e;

    typedef struct packed {
        logic ll;
        logic sc;
        logic plain_wr;
        logic rmw_rd;
        logic rmw_wr;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [2:0] kind);
        op_dec_t d;
        d          = '0;
        d.ll       = (kind == KIND_LL);
        d.sc       = (kind == KIND_SC);
        d.rmw_rd   = (kind == KIND_RMW_RD);
        d.rmw_wr   = (kind == KIND_RMW_WR);
        d.plain_wr = (kind == KIND_STORE) || d.rmw_rd || d.rmw_wr;
        return d;
    endfunction

endpackage

// File: rtl/llsc_rsv_slot.sv
module llsc_rsv_slot #(
    parameter int LINE_AW = 26,
    parameter int REQ_W   = 2,
    parameter int SLOT_ID = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [LINE_AW-1:0] set_line,
    input  logic               clr_en,
    output logic               rsv_valid,
    output logic [LINE_AW-1:0] rsv_line,
    output logic [REQ_W-1:0]   rsv_owner
);

    // Removal first, then a new reservation overrides it in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            rsv_valid <= 1'b0;
            rsv_line  <= '0;
            rsv_owner <= '0;
        end else if (set_en) begin
            rsv_valid <= 1'b1;
            rsv_line  <= set_line;
            rsv_owner <= REQ_W'(SLOT_ID);
        end else if (clr_en) begin
            rsv_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/llsc_resp_reg.sv
module llsc_resp_reg #(
    parameter int LINE_AW = 26,
    parameter int REQ_W   = 2,
    parameter int RES_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [REQ_W-1:0]   in_req,
    input  logic               in_ok,
    input  logic               in_hold,
    input  logic               in_release,
    input  logic [LINE_AW-1:0] in_line,
    output logic               res_valid,
    output logic [REQ_W-1:0]   res_req,
    output logic [RES_W-1:0]   res_word,
    output logic               qhold_valid,
    output logic [LINE_AW-1:0] qhold_line,
    output logic               qrelease_valid,
    output logic [LINE_AW-1:0] qrelease_line
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid      <= 1'b0;
            res_req        <= '0;
            res_word       <= '0;
            qhold_valid    <= 1'b0;
            qhold_line     <= '0;
            qrelease_valid <= 1'b0;
            qrelease_line  <= '0;
        end else begin
            res_valid      <= in_valid;
            qhold_valid    <= in_hold;
            qrelease_valid <= in_release;
            if (in_valid) begin
                res_req  <= in_req;
                res_word <= RES_W'(in_ok);
            end
            if (in_hold) begin
                qhold_line <= in_line;
            end
            if (in_release) begin
                qrelease_line <= in_line;
            end
        end
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_monitor_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int LINE_AW = 26,
    parameter int RES_W   = 32,
    localparam int REQ_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmp_valid,
    input  logic [2:0]         cmp_kind,
    input  logic [LINE_AW-1:0] cmp_line,
    input  logic [REQ_W-1:0]   cmp_req,
    input  logic               cmp_line_present,
    input  logic               evict_valid,
    input  logic [LINE_AW-1:0] evict_line,
    input  logic               bypass_en,
    output logic               res_valid,
    output logic [REQ_W-1:0]   res_req,
    output logic [RES_W-1:0]   res_word,
    output logic               qhold_valid,
    output logic [LINE_AW-1:0] qhold_line,
    output logic               qrelease_valid,
    output logic [LINE_AW-1:0] qrelease_line
);

    op_dec_t            dec;
    logic               act;
    logic [NUM_REQ-1:0] rsv_valid;
    logic [LINE_AW-1:0] rsv_line  [NUM_REQ];
    logic [REQ_W-1:0]   rsv_owner [NUM_REQ];
    logic [NUM_REQ-1:0] slot_set;
    logic [NUM_REQ-1:0] slot_clr;
    logic [NUM_REQ-1:0] sc_hit;
    logic               sc_ok;

    assign dec = decode_op(cmp_kind);
    assign act = cmp_valid && !bypass_en;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
        logic own, hit_cmp, hit_evict;

        assign own       = (cmp_req == REQ_W'(g));
        assign hit_cmp   = rsv_valid[g] && (rsv_line[g] == cmp_line);
        assign hit_evict = rsv_valid[g] && (rsv_line[g] == evict_line);

        assign slot_clr[g] = (evict_valid && hit_evict)
                           | (act && dec.sc && hit_cmp)
                           | (act && dec.plain_wr && own && cmp_line_present && hit_cmp);
        assign slot_set[g] = act && dec.ll && own;
        assign sc_hit[g]   = own && hit_cmp && (rsv_owner[g] == cmp_req);

        llsc_rsv_slot #(
            .LINE_AW (LINE_AW),
            .REQ_W   (REQ_W),
            .SLOT_ID (g)
        ) slot_i (
            .clk       (clk),
            .rst       (rst),
            .set_en    (slot_set[g]),
            .set_line  (cmp_line),
            .clr_en    (slot_clr[g]),
            .rsv_valid (rsv_valid[g]),
            .rsv_line  (rsv_line[g]),
            .rsv_owner (rsv_owner[g])
        );
    end

    assign sc_ok = !(act && dec.sc) || (|sc_hit);

    llsc_resp_reg #(
        .LINE_AW (LINE_AW),
        .REQ_W   (REQ_W),
        .RES_W   (RES_W)
    ) resp_i (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (cmp_valid),
        .in_req         (cmp_req),
        .in_ok          (sc_ok),
        .in_hold        (cmp_valid && dec.rmw_rd),
        .in_release     (cmp_valid && dec.rmw_wr),
        .in_line        (cmp_line),
        .res_valid      (res_valid),
        .res_req        (res_req),
        .res_word       (res_word),
        .qhold_valid    (qhold_valid),
        .qhold_line     (qhold_line),
        .qrelease_valid (qrelease_valid),
        .qrelease_line  (qrelease_line)
    );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int NUM_REQ = 4,
    parameter int LINE_AW = 26,
    parameter int RES_W   = 32,
    localparam int REQ_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               cmp_valid,
    input logic [2:0]         cmp_kind,
    input logic [LINE_AW-1:0] cmp_line,
    input logic [REQ_W-1:0]   cmp_req,
    input logic               bypass_en,
    input logic               res_valid,
    input logic [REQ_W-1:0]   res_req,
    input logic [RES_W-1:0]   res_word,
    input logic               qhold_valid,
    input logic [LINE_AW-1:0] qhold_line,
    input logic               qrelease_valid,
    input logic [LINE_AW-1:0] qrelease_line,
    input logic [NUM_REQ-1:0] rsv_valid
);

    AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> res_valid && (res_req == $past(cmp_req))); // R11

    AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> !res_valid); // R11

    AST_WORD_BINARY: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_word[RES_W-1:1] == '0)); // R11

    AST_LOAD_OK: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_kind == 3'd0) |=> (res_word == RES_W'(1))); // R6

    AST_BYPASS_OK: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && bypass_en) |=> (res_word == RES_W'(1))); // R8

    AST_LL_RESERVES: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !bypass_en && cmp_kind == 3'd2 && int'(cmp_req) < NUM_REQ)
        |=> rsv_valid[$past(cmp_req)]); // R10

    AST_HOLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_kind == 3'd4) |=> qhold_valid && (qhold_line == $past(cmp_line))); // R7

    AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_kind == 3'd5) |=> qrelease_valid && (qrelease_line == $past(cmp_line))); // R7

    AST_HOLD_ONLY_RMW: assert property (@(posedge clk) disable iff (rst)
        !(cmp_valid && cmp_kind == 3'd4) |=> !qhold_valid); // R7

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .NUM_REQ (NUM_REQ),
    .LINE_AW (LINE_AW),
    .RES_W   (RES_W)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .cmp_valid      (cmp_valid),
    .cmp_kind       (cmp_kind),
    .cmp_line       (cmp_line),
    .cmp_req        (cmp_req),
    .bypass_en      (bypass_en),
    .res_valid      (res_valid),
    .res_req        (res_req),
    .res_word       (res_word),
    .qhold_valid    (qhold_valid),
    .qhold_line     (qhold_line),
    .qrelease_valid (qrelease_valid),
    .qrelease_line  (qrelease_line),
    .rsv_valid      (rsv_valid)
);

// File: tb/llsc_monitor_tb_top.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;

    localparam int NREQ = 2;
    localparam int LAW  = 4;
    localparam int RW   = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cmp_valid = 1'b0;
    logic [2:0]     cmp_kind = '0;
    logic [LAW-1:0] cmp_line = '0;
    logic [0:0]     cmp_req = '0;
    logic           cmp_line_present = 1'b0;
    logic           evict_valid = 1'b0;
    logic [LAW-1:0] evict_line = '0;
    logic           bypass_en = 1'b0;
    logic           res_valid;
    logic [0:0]     res_req;
    logic [RW-1:0]  res_word;
    logic           qhold_valid;
    logic [LAW-1:0] qhold_line;
    logic           qrelease_valid;
    logic [LAW-1:0] qrelease_line;

    int checks = 0;
    int errors = 0;
    bit mv [NREQ];
    int ml [NREQ];

    always #2 clk = ~clk;

    llsc_monitor #(.NUM_REQ(NREQ), .LINE_AW(LAW), .RES_W(RW)) dut_i (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
        .cmp_line(cmp_line), .cmp_req(cmp_req), .cmp_line_present(cmp_line_present),
        .evict_valid(evict_valid), .evict_line(evict_line), .bypass_en(bypass_en),
        .res_valid(res_valid), .res_req(res_req), .res_word(res_word),
        .qhold_valid(qhold_valid), .qhold_line(qhold_line),
        .qrelease_valid(qrelease_valid), .qrelease_line(qrelease_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One completion, optionally with an eviction; called at a falling edge.
    task automatic step(input int k, input int line, input int id, input bit pres,
                        input bit byp, input bit ev, input int evl, input string req);
        int  exp;
        bit  nv [NREQ];
        exp = 1;
        if (k == 3 && !byp) exp = (mv[id] && ml[id] == line) ? 1 : 0;
        cmp_valid = 1'b1; cmp_kind = 3'(k); cmp_line = LAW'(line); cmp_req = 1'(id);
        cmp_line_present = pres; bypass_en = byp; evict_valid = ev; evict_line = LAW'(evl);
        @(negedge clk);
        chk(res_valid === 1'b1, req, int'(res_valid), 1);
        chk(res_req === 1'(id), req, int'(res_req), id);
        chk(res_word === RW'(exp), req, int'(res_word), exp);
        chk(qhold_valid === (k == 4) && (k != 4 || qhold_line == LAW'(line)), "R7",
            int'(qhold_valid), int'(k == 4));
        chk(qrelease_valid === (k == 5) && (k != 5 || qrelease_line == LAW'(line)), "R7",
            int'(qrelease_valid), int'(k == 5));
        cmp_valid = 1'b0; evict_valid = 1'b0; bypass_en = 1'b0;
        for (int r = 0; r < NREQ; r++) nv[r] = mv[r];
        if (ev)
            for (int r = 0; r < NREQ; r++) if (mv[r] && ml[r] == evl) nv[r] = 0;
        if (!byp) begin
            if (k == 3)
                for (int r = 0; r < NREQ; r++) if (mv[r] && ml[r] == line) nv[r] = 0;
            if ((k == 1 || k == 4 || k == 5) && pres && mv[id] && ml[id] == line) nv[id] = 0;
            if (k == 2) begin nv[id] = 1; ml[id] = line; end
        end
        for (int r = 0; r < NREQ; r++) mv[r] = nv[r];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREQ; r++) begin mv[r] = 0; ml[r] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset, and no reservation held
        chk(res_valid === 1'b0, "R1", int'(res_valid), 0);
        chk(qhold_valid === 1'b0 && qrelease_valid === 1'b0, "R1", int'(qhold_valid), 0);
        step(3, 3, 0, 1, 0, 0, 0, "R1");
        // R11: idle cycle produces no result
        @(negedge clk);
        chk(res_valid === 1'b0, "R11", int'(res_valid), 0);

        // Sweep: reserve, disturb, then store-conditional from both requesters
        for (int r = 0; r < NREQ; r++) begin
            for (int k = 0; k < 8; k++) begin
                for (int s = 0; s < 2; s++) begin
                    int o, l;
                    o = 1 - r;
                    l = (s == 1) ? 3 : 9;
                    step(2, 3, r, 1, 0, 0, 0, "R2");
                    case (k)
                        0: step(0, l, r, 1, 0, 0, 0, "R6");
                        1: step(1, l, r, 1, 0, 0, 0, "R5");
                        2: step(1, l, r, 0, 0, 0, 0, "R5");
                        3: step(1, l, o, 1, 0, 0, 0, "R5");
                        4: step(0, 0, r, 1, 0, 1, l, "R9");
                        5: step(3, l, o, 1, 0, 0, 0, "R4");
                        6: step(2, l, o, 1, 0, 0, 0, "R2");
                        default: begin
                            step(4, l, r, 1, 0, 0, 0, "R7");
                            step(5, l, r, 1, 0, 0, 0, "R7");
                        end
                    endcase
                    step(3, 3, r, 1, 0, 0, 0, "R3");
                    step(3, 3, o, 1, 0, 0, 0, "R4");
                end
            end
        end

        // R3: reservation on a different line
        step(2, 2, 0, 1, 0, 0, 0, "R2");
        step(3, 12, 0, 1, 0, 0, 0, "R3");
        step(3, 2, 0, 1, 0, 0, 0, "R2");

        // R10: load-linked and eviction of the same line together
        step(2, 6, 0, 1, 0, 1, 6, "R10");
        step(3, 6, 0, 1, 0, 0, 0, "R10");

        // R8: bypass neither sets nor clears
        step(2, 7, 1, 1, 1, 0, 0, "R8");
        step(3, 7, 1, 1, 0, 0, 0, "R8");
        step(2, 7, 1, 1, 0, 0, 0, "R8");
        step(3, 7, 1, 1, 1, 0, 0, "R8");
        step(3, 7, 1, 1, 0, 0, 0, "R8");
        step(3, 5, 0, 1, 1, 0, 0, "R8");

        // R6: unused codes behave as loads
        step(2, 4, 1, 1, 0, 0, 0, "R2");
        step(6, 4, 1, 1, 0, 0, 0, "R6");
        step(7, 4, 1, 1, 0, 0, 0, "R6");
        step(3, 4, 1, 1, 0, 0, 0, "R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule